// File: doc/BRIEF.md
# Programmable YUV to RGB Colour Converter

This block converts video pixels from limited-range BT.601 YUV (luma 16 to 235, chroma 16 to 240) into full-range 8-bit RGB. It accepts one pixel per cycle under a valid/ready handshake and returns the converted pixel a fixed number of cycles later. Each output channel is a weighted sum of the three input components plus an offset. The weights are fixed-point numbers scaled by 1024 and the offsets are scaled by 16.

Software can rewrite the twelve weights and offsets through a one-cycle write port. After reset the bank holds a BT.601 set, so the converter works correctly without any setup. A conversion-enable input, sampled together with each pixel, lets that pixel pass through unchanged. This is useful for sources that already carry RGB.

Top module: `yuv2rgb_cvt`

## Requirements
- R1: While reset is high and on the cycle after it, out_valid is low and out_pix is zero. Reset also restores the default coefficient set, so Y=16, U=128, V=128 converts to 0x000000 with no writes.
- R2: With the default set, each channel equals clamp(round((ky·Y + ku·U + kv·V + 64·kc) / 1024)). The defaults are G = (1191, −401, −833, +2167), R = (1191, 0, 1634, −3567) and B = (1191, 2066, 0, −4431). Y=235, U=128, V=128 converts to 0xFFFFFF.
- R3: The sum is formed at scale 1024. The block adds 512 and shifts right arithmetically by 10. A negative result is clamped to 0 and a result above 255 is clamped to 255.
- R4: Coefficient write addresses are row G at 0–3, row R at 4–7 and row B at 8–11. Within each row the order is Y weight, U weight, V weight, offset. A weight keeps cfg_wdata[12:0] as 13-bit two's complement and ignores bit 13. An offset keeps all 14 bits as two's complement in units of 1/16.
- R5: Writes to addresses 12 to 15 change no coefficient.
- R6: in_pix carries Y in bits [23:16], U in bits [15:8] and V in bits [7:0]. out_pix carries R in bits [23:16], G in bits [15:8] and B in bits [7:0].
- R7: A pixel is accepted on an edge where in_valid and in_ready are both high. If out_ready stays high, the pixel is on out_pix with out_valid high after the second following edge, which gives a latency of 3 edges. Cycles with no accepted pixel produce out_valid low at the same distance.
- R8: in_ready equals out_ready. While out_ready is low, nothing is accepted and out_valid and out_pix hold their values.
- R9: A pixel accepted with conv_en low comes out bit-for-bit unchanged, with the same latency as a converted pixel.
- R10: A pixel uses the coefficients that were in force before its acceptance edge. A write on that same edge applies from the next pixel onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Convert when high, pass through when low; sampled with each pixel |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient index |
| cfg_wdata | input | 14 | Coefficient value |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 24 | Input pixel Y/U/V |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready; low freezes the pipeline |
| out_pix | output | 24 | Output pixel R/G/B |

## Verification
Every result is due exactly three advancing edges after its acceptance edge. Edges with out_ready low do not count toward the three. The reference model in the bench therefore shifts its expected pixel through three slots only on edges where out_ready is high, and it compares out_valid and out_pix at each falling edge, midway between the edges that move data. The directed cases drive a pixel just after one edge and sample on the falling edge after the second following edge. This also checks that no extra stage is added or skipped. A coefficient write is applied to the model only after the pixel accepted on the same edge has been converted, which matches the timing in R10.

// File: rtl/yuv2rgb_pkg.sv
`timescale 1ns/1ps
package yuv2rgb_pkg;

    // Component and coefficient geometry
    localparam int PIX_W      = 8;
    localparam int NUM_CH     = 3;
    localparam int BUS_W      = PIX_W * NUM_CH;
    localparam int MUL_W      = 13;
    localparam int OFS_W      = 14;
    localparam int FRAC_W     = 10;
    localparam int OFS_FRAC_W = 4;
    localparam int OFS_SH     = FRAC_W - OFS_FRAC_W;
    localparam int TAPS       = 4;
    localparam int NUM_COEF   = NUM_CH * TAPS;
    localparam int ADDR_W     = $clog2(NUM_COEF + 4);
    localparam int PIPE_DEPTH = 3;
    localparam int PROD_W     = MUL_W + PIX_W + 1;
    localparam int ACC_W      = PROD_W + 3;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;

    // Row order inside the coefficient bank
    typedef enum logic [1:0] {
        ROW_G = 2'd0,
        ROW_R = 2'd1,
        ROW_B = 2'd2
    } row_e;

    typedef struct packed {
        logic signed [MUL_W-1:0] ky;
        logic signed [MUL_W-1:0] ku;
        logic signed [MUL_W-1:0] kv;
        logic signed [OFS_W-1:0] kc;
    } coef_row_t;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] u;
        logic [PIX_W-1:0] v;
    } yuv_t;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } rgb_t;

    // BT.601 limited-range to full-range set, loaded by reset
    function automatic logic [OFS_W-1:0] dflt_coef(input int idx);
        case (idx)
            0:  return 14'h04A7;
            1:  return 14'h1E6F;
            2:  return 14'h1CBF;
            3:  return 14'h0877;
            4:  return 14'h04A7;
            5:  return 14'h0000;
            6:  return 14'h0662;
            7:  return 14'h3211;
            8:  return 14'h04A7;
            9:  return 14'h0812;
            10: return 14'h0000;
            11: return 14'h2EB1;
            default: return '0;
        endcase
    endfunction

    // Clamp a signed integer result into the pixel range
    function automatic logic [PIX_W-1:0] clip_pix(input logic signed [ACC_W-1:0] val);
        if (val < 0)
            return '0;
        else if (val > ACC_W'(PIX_MAX))
            return PIX_W'(PIX_MAX);
        else
            return val[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/yuv2rgb_coef_bank.sv
`timescale 1ns/1ps
module yuv2rgb_coef_bank
    import yuv2rgb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [OFS_W-1:0]            wr_data,
    output coef_row_t [NUM_CH-1:0]      rows
);

    // One register per coefficient; offsets keep the full width,
    // weights keep only their two's-complement field.
    for (genvar i = 0; i < NUM_COEF; i++) begin : g_reg
        localparam bit IS_OFS = ((i % TAPS) == (TAPS - 1));
        localparam int W      = IS_OFS ? OFS_W : MUL_W;
        logic [W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= W'(dflt_coef(i));
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                q <= wr_data[W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_row
        assign rows[c].ky = g_reg[c*TAPS + 0].q;
        assign rows[c].ku = g_reg[c*TAPS + 1].q;
        assign rows[c].kv = g_reg[c*TAPS + 2].q;
        assign rows[c].kc = g_reg[c*TAPS + 3].q;
    end

endmodule

// File: rtl/yuv2rgb_channel.sv
`timescale 1ns/1ps
module yuv2rgb_channel
    import yuv2rgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  yuv_t             pix,
    input  coef_row_t        coef,
    output logic [PIX_W-1:0] res
);

    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));

    // Stage 1: three products and the offset lifted to scale 1024
    logic signed [PROD_W-1:0] py_q, pu_q, pv_q;
    logic signed [ACC_W-1:0]  kc_q;
    // Stage 2: rounded sum
    logic signed [ACC_W-1:0]  sum_q;
    // Stage 3: clamped result
    logic [PIX_W-1:0]         res_q;

    logic signed [PROD_W-1:0] sy, su, sv;
    assign sy = PROD_W'($signed({1'b0, pix.y}));
    assign su = PROD_W'($signed({1'b0, pix.u}));
    assign sv = PROD_W'($signed({1'b0, pix.v}));

    always_ff @(posedge clk) begin
        if (rst) begin
            py_q  <= '0;
            pu_q  <= '0;
            pv_q  <= '0;
            kc_q  <= '0;
            sum_q <= '0;
            res_q <= '0;
        end else if (adv) begin
            py_q  <= PROD_W'(coef.ky) * sy;
            pu_q  <= PROD_W'(coef.ku) * su;
            pv_q  <= PROD_W'(coef.kv) * sv;
            kc_q  <= ACC_W'(coef.kc) <<< OFS_SH;
            sum_q <= ACC_W'(py_q) + ACC_W'(pu_q) + ACC_W'(pv_q) + kc_q + RND;
            res_q <= clip_pix(sum_q >>> FRAC_W);
        end
    end

    assign res = res_q;

endmodule

// File: rtl/yuv2rgb_pipe_ctrl.sv
`timescale 1ns/1ps
module yuv2rgb_pipe_ctrl
    import yuv2rgb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic in_valid,
    input  logic in_byp,
    input  yuv_t in_pix,
    output logic out_valid,
    output logic out_byp,
    output yuv_t out_raw
);

    logic [PIPE_DEPTH-1:0] vld_q;
    logic [PIPE_DEPTH-1:0] byp_q;
    yuv_t                  raw_q [PIPE_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            byp_q <= '0;
        end else if (adv) begin
            vld_q <= {vld_q[PIPE_DEPTH-2:0], in_valid};
            byp_q <= {byp_q[PIPE_DEPTH-2:0], in_byp};
        end
    end

    // Raw pixel copy travels beside the arithmetic for the bypass case
    for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_raw
        always_ff @(posedge clk) begin
            if (rst)
                raw_q[s] <= '0;
            else if (adv)
                raw_q[s] <= (s == 0) ? in_pix : raw_q[(s == 0) ? 0 : s-1];
        end
    end

    assign out_valid = vld_q[PIPE_DEPTH-1];
    assign out_byp   = byp_q[PIPE_DEPTH-1];
    assign out_raw   = raw_q[PIPE_DEPTH-1];

endmodule

// File: rtl/yuv2rgb_cvt.sv
`timescale 1ns/1ps
module yuv2rgb_cvt
    import yuv2rgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [OFS_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_pix
);

    logic                  adv;
    yuv_t                  pix_in;
    coef_row_t [NUM_CH-1:0] rows;
    logic [PIX_W-1:0]      ch_res [NUM_CH];
    logic                  byp_out;
    yuv_t                  raw_out;
    rgb_t                  rgb;

    // Whole pipeline moves only when the consumer can take a pixel
    assign adv      = out_ready;
    assign in_ready = out_ready;
    assign pix_in   = yuv_t'(in_pix);

    yuv2rgb_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rows    (rows)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        yuv2rgb_channel u_ch (
            .clk  (clk),
            .rst  (rst),
            .adv  (adv),
            .pix  (pix_in),
            .coef (rows[c]),
            .res  (ch_res[c])
        );
    end

    yuv2rgb_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .in_valid  (in_valid),
        .in_byp    (~conv_en),
        .in_pix    (pix_in),
        .out_valid (out_valid),
        .out_byp   (byp_out),
        .out_raw   (raw_out)
    );

    assign rgb.r = ch_res[ROW_R];
    assign rgb.g = ch_res[ROW_G];
    assign rgb.b = ch_res[ROW_B];

    assign out_pix = byp_out ? BUS_W'(raw_out) : BUS_W'(rgb);

endmodule

// File: rtl/yuv2rgb_chk.sv
`timescale 1ns/1ps
module yuv2rgb_chk
    import yuv2rgb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             conv_en,
    input logic             in_valid,
    input logic [BUS_W-1:0] in_pix,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_pix
);

    // Edges seen since reset was released, saturating
    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 3'd7)
            age <= age + 3'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_pix == '0));

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd3 && $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3))
        |-> (out_valid == $past(in_valid, 3)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_ready |=> ($stable(out_valid) && $stable(out_pix)));

    // R9
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd3 && $past(out_ready, 1) && $past(out_ready, 2) && $past(out_ready, 3)
         && $past(in_valid && !conv_en, 3))
        |-> (out_pix == $past(in_pix, 3)));

endmodule

bind yuv2rgb_cvt yuv2rgb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_en   (conv_en),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
);

// File: tb/yuv2rgb_cvt_test.sv
`timescale 1ns/1ps
module yuv2rgb_cvt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pix;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    yuv2rgb_cvt uut (
        .clk       (clk),
        .rst       (rst),
        .conv_en   (conv_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int        cf [12];
    bit        mv [3];
    bit [23:0] md [3];

    function automatic int sx(input int raw, input int w);
        int m;
        m = raw & ((1 << w) - 1);
        if (m >= (1 << (w - 1))) m -= (1 << w);
        return m;
    endfunction

    function automatic bit [23:0] ref_conv(input bit [23:0] p);
        int comp [3];
        bit [7:0] o [3];
        comp[0] = int'(p[23:16]);
        comp[1] = int'(p[15:8]);
        comp[2] = int'(p[7:0]);
        for (int c = 0; c < 3; c++) begin
            int acc;
            acc = sx(cf[4*c+3], 14) * 64 + 512;
            for (int k = 0; k < 3; k++) acc += sx(cf[4*c+k], 13) * comp[k];
            acc = acc >>> 10;
            if (acc < 0) acc = 0;
            else if (acc > 255) acc = 255;
            o[c] = 8'(acc);
        end
        // rows are G,R,B; output bytes are R,G,B
        return {o[1], o[0], o[2]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 3; s++) begin
                mv[s] = 1'b0;
                md[s] = '0;
            end
            cf = '{32'h04A7, 32'h1E6F, 32'h1CBF, 32'h0877,
                   32'h04A7, 32'h0000, 32'h0662, 32'h3211,
                   32'h04A7, 32'h0812, 32'h0000, 32'h2EB1};
        end else begin
            if (out_ready) begin
                mv[2] = mv[1]; md[2] = md[1];
                mv[1] = mv[0]; md[1] = md[0];
                mv[0] = in_valid;
                md[0] = conv_en ? ref_conv(in_pix) : in_pix;
            end
            // write lands after the pixel on this edge used the old set (R10)
            if (cfg_we && cfg_addr < 12)
                cf[cfg_addr] = ((cfg_addr % 4) == 3) ? int'(cfg_wdata) : int'(cfg_wdata[12:0]);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(out_valid == mv[2], "R7 valid timing", {23'd0, out_valid}, {23'd0, mv[2]});
            if (mv[2] && out_valid)
                check(out_pix == md[2], "R2 model pixel", out_pix, md[2]);
            check(in_ready == out_ready, "R8 ready", {23'd0, in_ready}, {23'd0, out_ready});
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [13:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic conv_one(input logic [23:0] p, input bit en, input logic [23:0] exp, input string tag);
        in_pix = p; conv_en = en; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; conv_en = 1'b1; cfg_we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b1 && out_pix === exp, tag, out_pix, exp);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        logic [23:0] held;
        logic        hv;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_pix == 24'h0, "R1 reset state", out_pix, 24'h0);
        @(posedge clk); #1;
        rst = 1'b0;

        conv_one(24'h108080, 1'b1, 24'h000000, "R1 default black");
        conv_one(24'hEB8080, 1'b1, 24'hFFFFFF, "R2 default white");
        conv_one(24'h101010, 1'b1, 24'h008700, "R3 clamp low");
        conv_one(24'hEB80F0, 1'b1, 24'hFFA3FF, "R3 clamp high");
        conv_one(24'h123456, 1'b0, 24'h123456, "R9 bypass");

        // R row: weight 0.5 written with bit 13 set, rest zero
        wr(4'd4, 14'h2200); wr(4'd5, 14'h0); wr(4'd6, 14'h0); wr(4'd7, 14'h0);
        conv_one(24'h038080, 1'b1, 24'h020000, "R4 bit13 ignored, R3 round 1.5");
        conv_one(24'h028080, 1'b1, 24'h010000, "R3 round 1.0");

        wr(4'd12, 14'h1FFF); wr(4'd13, 14'h1FFF); wr(4'd14, 14'h3FFF); wr(4'd15, 14'h3FFF);
        conv_one(24'h038080, 1'b1, 24'h020000, "R5 spare addresses");

        // R10: write weight 1.0 on the acceptance edge of a pixel
        cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 14'h0400;
        conv_one(24'h038080, 1'b1, 24'h020000, "R10 old set");
        conv_one(24'h038080, 1'b1, 24'h030000, "R10 new set");
        conv_one(24'hC80000, 1'b1, 24'hC8FF00, "R6 byte order");

        wr(4'd7, 14'h0010);
        conv_one(24'h038080, 1'b1, 24'h040000, "R4 positive offset");
        wr(4'd7, 14'h3FE0);
        conv_one(24'h038080, 1'b1, 24'h010000, "R4 negative offset");

        // R8: fill, then stall with a pixel waiting
        in_valid = 1'b1; in_pix = 24'h408080;
        @(posedge clk); #1; in_pix = 24'h508080;
        @(posedge clk); #1; in_pix = 24'h608080;
        @(posedge clk); #1; in_pix = 24'h708080; out_ready = 1'b0;
        @(negedge clk);
        held = out_pix; hv = out_valid;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_pix == held && out_valid == hv && !in_ready, "R8 stall hold", out_pix, held);
        end
        @(posedge clk); #1; out_ready = 1'b1;
        @(posedge clk); #1; in_valid = 1'b0;
        repeat (5) @(posedge clk); #1;

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            in_valid  = ($urandom_range(0, 3) != 0);
            in_pix    = 24'($urandom);
            conv_en   = ($urandom_range(0, 7) != 0);
            out_ready = ($urandom_range(0, 3) != 0);
            cfg_we    = ($urandom_range(0, 31) == 0);
            cfg_addr  = 4'($urandom);
            cfg_wdata = 14'($urandom);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b1; conv_en = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

    initial begin
        #600000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R7 actual=%h expected=%h", 24'h0, 24'h1);
            finish_run();
        end
    end

endmodule